// File: doc/BRIEF.md
# Core Module Control and Lock Register Block

This block is the register file of a processor core module. It sits on a simple 32-bit register bus that carries one access per cycle, addressed in words. It returns fixed identification and status words and keeps oscillator settings that change only while a 16-bit unlock key is held. It has two flag registers, each with a set address and a clear address, SDRAM and init configuration words, and a control word. The control word drives the LED, selects whether boot flash or RAM appears at address zero, and can request a board reset.

A small interrupt section holds one software interrupt bit and two independent enable masks, one for IRQ and one for FIQ. Each output line is the registered OR of its masked status. Read data and the error flag appear in the cycle after the request. An access to a word that does not exist is flagged for one cycle and changes nothing.

Top module: `coremod_regs`

## Requirements
- R1: Reading word 0 returns 0x411A3001, word 1 returns 0 and word 4 returns 0x00100000. Writes to these words change nothing and raise the error flag.
- R2: A write to word 5 keeps only data bits 15:0. Reading word 5 returns 0x0001A05F while the kept value equals the key 0xA05F, and the kept value otherwise.
- R3: Writes to word 2 (oscillator) and word 7 (auxiliary oscillator) take effect only while the key is held. Otherwise they are dropped without an error.
- R4: Writing word 12 ORs the data into the general flags, and writing word 13 clears the bits that are one in the data. Words 14 and 15 do the same for the non-volatile flags. Words 12 and 14 read the current values.
- R5: After reset, word 2 reads 0x01000048, word 7 reads 0x0007FEFF, word 9 reads 0x00000112 and word 8 reads 0x00011122 ORed with the size code. The size code is 0x10 for 256 MB or more, 0x0C for 128 MB or more, 0x08 for 64 MB or more, 0x04 for 32 MB or more, and 0 below that. Words 8 and 9 are fully writable. Locks, flags, enables and the soft bit reset to zero.
- R6: A write to word 3 stores data bit 0 as the LED output and data bit 2 as the remap bit. The output `bootFlashSel` is high while the remap bit is 0. Reading word 3 returns these two bits in bits 0 and 2. The outputs change one cycle after the write.
- R7: A write to word 3 with data bit 3 set makes `boardRstReq` high for exactly the one cycle after the write.
- R8: Word 18 sets IRQ enable bits and word 19 clears them. Word 26 sets FIQ enable bits and word 27 clears them. Word 20 sets the soft bit and word 21 clears it, using only data bit 0. The raw level has the soft bit at bit 0. Words 17 and 25 read the raw level, word 16 reads the level ANDed with the IRQ enables, word 24 reads the level ANDed with the FIQ enables, words 18 and 26 read the enables, and word 20 reads the soft bit.
- R9: `irqOut` and `fiqOut` are the OR of the IRQ and FIQ masked status, registered. Each one follows a state change one cycle later.
- R10: Words 32 to 35 read zero without an error. Writes to them change nothing and raise no error.
- R11: Any other word is unimplemented. This includes reads of words 13, 15, 19, 21 and 27. Such a read returns zero and such a write changes no state. Either one raises `busErr` for one cycle.
- R12: `busRdata` and `busErr` are valid in the cycle after the request. Back-to-back accesses are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| busErr | output | 1 | One-cycle flag for an unimplemented access |
| bootFlashSel | output | 1 | High while flash is mapped at address zero |
| ledOut | output | 1 | LED drive |
| boardRstReq | output | 1 | One-cycle board reset request |
| irqOut | output | 1 | Registered IRQ line |
| fiqOut | output | 1 | Registered FIQ line |

## Verification
The bench builds the block with MEM_MB = 256, so the SDRAM word must come out of reset with the largest size code, 0x00011132. That value tests the top branch of the size mapping. The default key 0xA05F and ADDR_W = 6 are kept, which puts every word up to 63 within reach, including the voltage words and unimplemented words above them. Because the bench writes a lock value with bits above 15 set and then reads it back, it also shows that the 16-bit truncation and the unlocked readback encoding are separate effects.

// File: rtl/coremod_pkg.sv
package coremod_pkg;

  localparam logic [31:0] ID_WORD     = 32'h411A3001;
  localparam logic [31:0] STATUS_WORD = 32'h00100000;
  localparam logic [31:0] OSC_RESET   = 32'h01000048;
  localparam logic [31:0] AUX_RESET   = 32'h0007FEFF;
  localparam logic [31:0] INIT_RESET  = 32'h00000112;
  localparam logic [31:0] SDRAM_BASE  = 32'h00011122;
  localparam int          NUM_CHAN    = 2;   // 0 = IRQ, 1 = FIQ

  // word indices
  localparam int unsigned W_ID      = 0;
  localparam int unsigned W_PROC    = 1;
  localparam int unsigned W_OSC     = 2;
  localparam int unsigned W_CTRL    = 3;
  localparam int unsigned W_STAT    = 4;
  localparam int unsigned W_LOCK    = 5;
  localparam int unsigned W_AUX     = 7;
  localparam int unsigned W_SDRAM   = 8;
  localparam int unsigned W_INIT    = 9;
  localparam int unsigned W_FLGSET  = 12;
  localparam int unsigned W_FLGCLR  = 13;
  localparam int unsigned W_NVSET   = 14;
  localparam int unsigned W_NVCLR   = 15;
  localparam int unsigned W_IMASK   = 16;
  localparam int unsigned W_IRAW    = 17;
  localparam int unsigned W_IENSET  = 18;
  localparam int unsigned W_IENCLR  = 19;
  localparam int unsigned W_SOFTSET = 20;
  localparam int unsigned W_SOFTCLR = 21;
  localparam int unsigned W_FMASK   = 24;
  localparam int unsigned W_FRAW    = 25;
  localparam int unsigned W_FENSET  = 26;
  localparam int unsigned W_FENCLR  = 27;
  localparam int unsigned W_VOLT0   = 32;
  localparam int unsigned W_VOLT3   = 35;

  typedef enum logic [3:0] {
    RS_ZERO, RS_ID, RS_OSC, RS_CTRL, RS_STAT, RS_LOCK, RS_AUX,
    RS_SDRAM, RS_INIT, RS_FLAG, RS_MASK, RS_RAW, RS_EN, RS_SOFT
  } rdSel_e;

  typedef struct packed {
    logic                wrOsc;
    logic                wrAux;
    logic                wrCtrl;
    logic                wrLock;
    logic                wrSdram;
    logic                wrInit;
    logic [NUM_CHAN-1:0] setFlag;   // 0 = general, 1 = non-volatile
    logic [NUM_CHAN-1:0] clrFlag;
    logic [NUM_CHAN-1:0] setEn;     // 0 = IRQ, 1 = FIQ
    logic [NUM_CHAN-1:0] clrEn;
    logic                setSoft;
    logic                clrSoft;
    logic                rdEn;
    rdSel_e              rdSel;
    logic                rdIdx;     // which flag/channel a read picks
  } cmStrobe_t;

  function automatic logic [31:0] sdramSizeCode(input int mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

endpackage

// File: rtl/coremod_decode.sv
module coremod_decode
  import coremod_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              unlocked,
  output cmStrobe_t         stb,
  output logic              busErr
);

  int unsigned wordIdx;
  logic        legal;

  assign wordIdx = 32'(busAddr);

  always_comb begin
    stb       = '0;
    stb.rdSel = RS_ZERO;
    legal     = 1'b0;
    if (busValid && busWrite) begin
      legal = 1'b1;
      case (wordIdx)
        W_OSC:     stb.wrOsc      = unlocked;
        W_CTRL:    stb.wrCtrl     = 1'b1;
        W_LOCK:    stb.wrLock     = 1'b1;
        W_AUX:     stb.wrAux      = unlocked;
        W_SDRAM:   stb.wrSdram    = 1'b1;
        W_INIT:    stb.wrInit     = 1'b1;
        W_FLGSET:  stb.setFlag[0] = 1'b1;
        W_FLGCLR:  stb.clrFlag[0] = 1'b1;
        W_NVSET:   stb.setFlag[1] = 1'b1;
        W_NVCLR:   stb.clrFlag[1] = 1'b1;
        W_IENSET:  stb.setEn[0]   = 1'b1;
        W_IENCLR:  stb.clrEn[0]   = 1'b1;
        W_FENSET:  stb.setEn[1]   = 1'b1;
        W_FENCLR:  stb.clrEn[1]   = 1'b1;
        W_SOFTSET: stb.setSoft    = 1'b1;
        W_SOFTCLR: stb.clrSoft    = 1'b1;
        default:   legal = (wordIdx >= W_VOLT0) && (wordIdx <= W_VOLT3);
      endcase
    end else if (busValid) begin
      stb.rdEn = 1'b1;
      legal    = 1'b1;
      case (wordIdx)
        W_ID:      stb.rdSel = RS_ID;
        W_PROC:    stb.rdSel = RS_ZERO;
        W_OSC:     stb.rdSel = RS_OSC;
        W_CTRL:    stb.rdSel = RS_CTRL;
        W_STAT:    stb.rdSel = RS_STAT;
        W_LOCK:    stb.rdSel = RS_LOCK;
        W_AUX:     stb.rdSel = RS_AUX;
        W_SDRAM:   stb.rdSel = RS_SDRAM;
        W_INIT:    stb.rdSel = RS_INIT;
        W_FLGSET:  stb.rdSel = RS_FLAG;
        W_NVSET:   begin stb.rdSel = RS_FLAG; stb.rdIdx = 1'b1; end
        W_IMASK:   stb.rdSel = RS_MASK;
        W_FMASK:   begin stb.rdSel = RS_MASK; stb.rdIdx = 1'b1; end
        W_IRAW,
        W_FRAW:    stb.rdSel = RS_RAW;
        W_IENSET:  stb.rdSel = RS_EN;
        W_FENSET:  begin stb.rdSel = RS_EN; stb.rdIdx = 1'b1; end
        W_SOFTSET: stb.rdSel = RS_SOFT;
        default:   legal = (wordIdx >= W_VOLT0) && (wordIdx <= W_VOLT3);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busErr <= 1'b0;
    else     busErr <= busValid && !legal;
  end

endmodule

// File: rtl/coremod_datapath.sv
module coremod_datapath
  import coremod_pkg::*;
#(
  parameter int          MEM_MB   = 128,
  parameter logic [15:0] LOCK_KEY = 16'hA05F
) (
  input  logic        clk,
  input  logic        rst,
  input  cmStrobe_t   stb,
  input  logic [31:0] wrData,
  output logic        unlocked,
  output logic [31:0] rdData,
  output logic        bootFlashSel,
  output logic        ledOut,
  output logic        boardRstReq,
  output logic        irqOut,
  output logic        fiqOut
);

  localparam logic [31:0] SDRAM_RESET = SDRAM_BASE | sdramSizeCode(MEM_MB);
  localparam logic [31:0] LOCK_OPEN   = {15'b0, 1'b1, LOCK_KEY};

  logic [31:0] oscReg, auxReg, sdramReg, initReg;
  logic [15:0] lockReg;
  logic        ledReg, remapReg, rstPulse, softBit;
  logic [31:0] flagReg [NUM_CHAN];
  logic [31:0] enReg   [NUM_CHAN];
  logic [31:0] rawLevel;
  logic [NUM_CHAN-1:0] lineReg;
  logic [31:0] rdNext;

  assign unlocked = (lockReg == LOCK_KEY);
  assign rawLevel = {31'b0, softBit};

  always_ff @(posedge clk) begin
    if (rst) begin
      oscReg   <= OSC_RESET;
      auxReg   <= AUX_RESET;
      sdramReg <= SDRAM_RESET;
      initReg  <= INIT_RESET;
      lockReg  <= '0;
      ledReg   <= 1'b0;
      remapReg <= 1'b0;
      rstPulse <= 1'b0;
      softBit  <= 1'b0;
    end else begin
      if (stb.wrOsc)   oscReg   <= wrData;
      if (stb.wrAux)   auxReg   <= wrData;
      if (stb.wrSdram) sdramReg <= wrData;
      if (stb.wrInit)  initReg  <= wrData;
      if (stb.wrLock)  lockReg  <= wrData[15:0];
      if (stb.wrCtrl) begin
        ledReg   <= wrData[0];
        remapReg <= wrData[2];
      end
      rstPulse <= stb.wrCtrl && wrData[3];
      if (stb.setSoft && wrData[0])      softBit <= 1'b1;
      else if (stb.clrSoft && wrData[0]) softBit <= 1'b0;
    end
  end

  // flag pairs and interrupt channels share the same set/clear shape
  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        flagReg[g] <= '0;
        enReg[g]   <= '0;
        lineReg[g] <= 1'b0;
      end else begin
        if (stb.setFlag[g])      flagReg[g] <= flagReg[g] | wrData;
        else if (stb.clrFlag[g]) flagReg[g] <= flagReg[g] & ~wrData;
        if (stb.setEn[g])        enReg[g]   <= enReg[g] | wrData;
        else if (stb.clrEn[g])   enReg[g]   <= enReg[g] & ~wrData;
        lineReg[g] <= |(rawLevel & enReg[g]);
      end
    end
  end

  always_comb begin
    case (stb.rdSel)
      RS_ID:    rdNext = ID_WORD;
      RS_OSC:   rdNext = oscReg;
      RS_CTRL:  rdNext = {29'b0, remapReg, 1'b0, ledReg};
      RS_STAT:  rdNext = STATUS_WORD;
      RS_LOCK:  rdNext = unlocked ? LOCK_OPEN : {16'b0, lockReg};
      RS_AUX:   rdNext = auxReg;
      RS_SDRAM: rdNext = sdramReg;
      RS_INIT:  rdNext = initReg;
      RS_FLAG:  rdNext = flagReg[stb.rdIdx];
      RS_MASK:  rdNext = rawLevel & enReg[stb.rdIdx];
      RS_RAW:   rdNext = rawLevel;
      RS_EN:    rdNext = enReg[stb.rdIdx];
      RS_SOFT:  rdNext = rawLevel;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
    else               rdData <= '0;
  end

  assign bootFlashSel = ~remapReg;
  assign ledOut       = ledReg;
  assign boardRstReq  = rstPulse;
  assign irqOut       = lineReg[0];
  assign fiqOut       = lineReg[1];

endmodule

// File: rtl/coremod_regs.sv
module coremod_regs
  import coremod_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          MEM_MB   = 128,
  parameter logic [15:0] LOCK_KEY = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  output logic              bootFlashSel,
  output logic              ledOut,
  output logic              boardRstReq,
  output logic              irqOut,
  output logic              fiqOut
);

  cmStrobe_t stb;
  logic      unlocked;

  coremod_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rst      (rst),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .unlocked (unlocked),
    .stb      (stb),
    .busErr   (busErr)
  );

  coremod_datapath #(.MEM_MB(MEM_MB), .LOCK_KEY(LOCK_KEY)) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .wrData       (busWdata),
    .unlocked     (unlocked),
    .rdData       (busRdata),
    .bootFlashSel (bootFlashSel),
    .ledOut       (ledOut),
    .boardRstReq  (boardRstReq),
    .irqOut       (irqOut),
    .fiqOut       (fiqOut)
  );

endmodule

// File: rtl/coremod_regs_chk.sv
module coremod_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              busErr,
  input logic              ledOut,
  input logic              boardRstReq,
  input logic              irqOut,
  input logic              fiqOut
);

  logic ctrlWrite;
  assign ctrlWrite = busValid && busWrite && (busAddr == ADDR_W'(3));

  assert_id_read_R1: assert property (@(posedge clk) disable iff (rst)
    (busValid && !busWrite && busAddr == ADDR_W'(0)) |=> (busRdata == 32'h411A3001));

  assert_led_cause_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(ledOut) |-> $past(ctrlWrite));

  assert_rst_single_R7: assert property (@(posedge clk) disable iff (rst)
    boardRstReq |=> !boardRstReq);

  assert_rst_cause_R7: assert property (@(posedge clk) disable iff (rst)
    boardRstReq |-> $past(ctrlWrite && busWdata[3]));

  assert_irq_lag_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(irqOut) |-> $past(busValid && busWrite, 2));

  assert_fiq_lag_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(fiqOut) |-> $past(busValid && busWrite, 2));

  assert_volt_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (busValid && !busWrite && busAddr >= ADDR_W'(32) && busAddr <= ADDR_W'(35))
      |=> (busRdata == 32'h0 && !busErr));

  assert_err_cause_R11: assert property (@(posedge clk) disable iff (rst)
    busErr |-> $past(busValid));

endmodule

bind coremod_regs coremod_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busValid    (busValid),
  .busWrite    (busWrite),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .busRdata    (busRdata),
  .busErr      (busErr),
  .ledOut      (ledOut),
  .boardRstReq (boardRstReq),
  .irqOut      (irqOut),
  .fiqOut      (fiqOut)
);

// File: tb/test_coremod_regs.sv
`timescale 1ns/1ps
module test_coremod_regs;

  localparam int ADDR_W = 6;
  localparam int MEM_MB = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              busErr, bootFlashSel, ledOut, boardRstReq, irqOut, fiqOut;

  always #4 clk = ~clk;

  coremod_regs #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) i_coremod_regs (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .bootFlashSel(bootFlashSel), .ledOut(ledOut),
    .boardRstReq(boardRstReq), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    logic        chkData;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checkCnt = 0;
  int  failCnt  = 0;
  logic respDue = 1'b0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compares each response the cycle after its request
  always @(posedge clk) respDue <= busValid && !rst;

  always @(negedge clk) begin
    if (respDue) begin
      if (expQ.size() == 0) begin
        check(1'b0, "scoreboard underflow", 32'h0, 32'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (it.chkData)
          check(busRdata == it.data, {it.tag, " data"}, busRdata, it.data);
        check(busErr == it.err, {it.tag, " err"}, {31'b0, busErr}, {31'b0, it.err});
      end
    end
  end

  task automatic doRead(input int addr, input logic [31:0] exp, input logic err, input string tag);
    expItem_t it;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = ADDR_W'(addr); busWdata = '0;
    it.data = exp; it.err = err; it.chkData = 1'b1; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic doWrite(input int addr, input logic [31:0] val, input logic err, input string tag);
    expItem_t it;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = ADDR_W'(addr); busWdata = val;
    it.data = '0; it.err = err; it.chkData = 1'b0; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state of outputs
    check(bootFlashSel == 1'b1, "R6 reset bootFlashSel", {31'b0, bootFlashSel}, 32'h1);
    check(ledOut == 1'b0, "R6 reset led", {31'b0, ledOut}, 32'h0);
    check(boardRstReq == 1'b0, "R7 reset request", {31'b0, boardRstReq}, 32'h0);
    check(irqOut == 1'b0 && fiqOut == 1'b0, "R9 reset lines", {30'b0, irqOut, fiqOut}, 32'h0);

    // R1 constants, R5 reset values, R12 back-to-back reads
    doRead(0, 32'h411A3001, 1'b0, "R1 id");
    doRead(1, 32'h0, 1'b0, "R1 proc");
    doRead(4, 32'h00100000, 1'b0, "R1 status");
    doRead(2, 32'h01000048, 1'b0, "R5 osc reset");
    doRead(7, 32'h0007FEFF, 1'b0, "R5 aux reset");
    doRead(9, 32'h00000112, 1'b0, "R5 init reset");
    doRead(8, 32'h00011132, 1'b0, "R5 sdram reset");
    doRead(5, 32'h0, 1'b0, "R2 lock reset");
    doRead(12, 32'h0, 1'b0, "R5 flags reset");
    doRead(3, 32'h0, 1'b0, "R6 ctrl reset");

    // R3 locked writes dropped, R2 lock readback
    doWrite(2, 32'h00001234, 1'b0, "R3 osc locked write");
    doWrite(7, 32'h00000077, 1'b0, "R3 aux locked write");
    doRead(2, 32'h01000048, 1'b0, "R3 osc unchanged");
    doRead(7, 32'h0007FEFF, 1'b0, "R3 aux unchanged");
    doWrite(5, 32'hFFFFA05F, 1'b0, "R2 unlock");
    doRead(5, 32'h0001A05F, 1'b0, "R2 unlocked readback");
    doWrite(2, 32'hCAFE0001, 1'b0, "R3 osc unlocked write");
    doWrite(7, 32'h00000055, 1'b0, "R3 aux unlocked write");
    doRead(2, 32'hCAFE0001, 1'b0, "R3 osc updated");
    doRead(7, 32'h00000055, 1'b0, "R3 aux updated");
    doWrite(5, 32'h00012345, 1'b0, "R2 relock");
    doRead(5, 32'h00002345, 1'b0, "R2 low half kept");
    doWrite(2, 32'h00000999, 1'b0, "R3 osc relocked write");
    doRead(2, 32'hCAFE0001, 1'b0, "R3 osc held");

    // R4 flags
    doWrite(12, 32'h000000F0, 1'b0, "R4 set a");
    doWrite(12, 32'h0000000F, 1'b0, "R4 set b");
    doRead(12, 32'h000000FF, 1'b0, "R4 flags or");
    doWrite(13, 32'h0000003C, 1'b0, "R4 clear");
    doRead(12, 32'h000000C3, 1'b0, "R4 flags cleared");
    doWrite(14, 32'h0000A5A5, 1'b0, "R4 nv set");
    doWrite(15, 32'h00000005, 1'b0, "R4 nv clear");
    doRead(14, 32'h0000A5A0, 1'b0, "R4 nv value");
    doRead(12, 32'h000000C3, 1'b0, "R4 flags independent");

    // R5 writable config words
    doWrite(8, 32'h0000DEAD, 1'b0, "R5 sdram write");
    doWrite(9, 32'h00000077, 1'b0, "R5 init write");
    doRead(8, 32'h0000DEAD, 1'b0, "R5 sdram readback");
    doRead(9, 32'h00000077, 1'b0, "R5 init readback");

    // R6 / R7 control
    doWrite(3, 32'h00000005, 1'b0, "R6 ctrl write");
    check(ledOut == 1'b1, "R6 led on", {31'b0, ledOut}, 32'h1);
    check(bootFlashSel == 1'b0, "R6 remap to ram", {31'b0, bootFlashSel}, 32'h0);
    check(boardRstReq == 1'b0, "R7 no request", {31'b0, boardRstReq}, 32'h0);
    doRead(3, 32'h00000005, 1'b0, "R6 ctrl readback");
    doWrite(3, 32'h00000008, 1'b0, "R7 reset write");
    check(boardRstReq == 1'b1, "R7 pulse high", {31'b0, boardRstReq}, 32'h1);
    check(ledOut == 1'b0 && bootFlashSel == 1'b1, "R6 bits cleared",
          {30'b0, ledOut, bootFlashSel}, 32'h1);
    @(negedge clk);
    check(boardRstReq == 1'b0, "R7 pulse one cycle", {31'b0, boardRstReq}, 32'h0);

    // R8 / R9 interrupts
    doWrite(18, 32'h00000001, 1'b0, "R8 irq enable");
    doWrite(20, 32'hFFFFFFFE, 1'b0, "R8 soft set bit0 clear");
    doRead(17, 32'h0, 1'b0, "R8 soft ignores upper bits");
    doWrite(20, 32'h00000001, 1'b0, "R8 soft set");
    check(irqOut == 1'b0, "R9 irq one cycle later", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check(irqOut == 1'b1, "R9 irq asserted", {31'b0, irqOut}, 32'h1);
    check(fiqOut == 1'b0, "R9 fiq masked", {31'b0, fiqOut}, 32'h0);
    doRead(17, 32'h1, 1'b0, "R8 irq raw");
    doRead(16, 32'h1, 1'b0, "R8 irq masked");
    doRead(24, 32'h0, 1'b0, "R8 fiq masked zero");
    doRead(25, 32'h1, 1'b0, "R8 fiq raw");
    doRead(20, 32'h1, 1'b0, "R8 soft read");
    doRead(18, 32'h1, 1'b0, "R8 irq enable read");
    doWrite(26, 32'hFFFFFFFF, 1'b0, "R8 fiq enable");
    check(fiqOut == 1'b0, "R9 fiq one cycle later", {31'b0, fiqOut}, 32'h0);
    @(negedge clk);
    check(fiqOut == 1'b1, "R9 fiq asserted", {31'b0, fiqOut}, 32'h1);
    doWrite(27, 32'hFFFFFFFE, 1'b0, "R8 fiq enable clear");
    doRead(26, 32'h1, 1'b0, "R8 fiq enable read");
    doWrite(19, 32'h00000001, 1'b0, "R8 irq enable clear");
    @(negedge clk);
    check(irqOut == 1'b0, "R9 irq released", {31'b0, irqOut}, 32'h0);
    doRead(16, 32'h0, 1'b0, "R8 irq masked off");
    doWrite(21, 32'hFFFFFFFE, 1'b0, "R8 soft clear bit0 zero");
    doRead(17, 32'h1, 1'b0, "R8 soft kept");
    doWrite(21, 32'h00000001, 1'b0, "R8 soft clear");
    @(negedge clk);
    check(fiqOut == 1'b0, "R9 fiq released", {31'b0, fiqOut}, 32'h0);
    doRead(25, 32'h0, 1'b0, "R8 raw cleared");

    // R10 voltage words
    doWrite(33, 32'hFFFFFFFF, 1'b0, "R10 volt write");
    doRead(33, 32'h0, 1'b0, "R10 volt read");
    doRead(35, 32'h0, 1'b0, "R10 volt top");

    // R11 unimplemented
    doRead(6, 32'h0, 1'b1, "R11 read word6");
    doRead(13, 32'h0, 1'b1, "R11 read clear addr");
    doRead(40, 32'h0, 1'b1, "R11 read high word");
    doWrite(6, 32'hFFFFFFFF, 1'b1, "R11 write word6");
    doWrite(0, 32'h0, 1'b1, "R1 write id");
    doWrite(11, 32'hFFFFFFFF, 1'b1, "R11 write word11");
    doRead(0, 32'h411A3001, 1'b0, "R1 id unchanged");
    doRead(12, 32'h000000C3, 1'b0, "R11 flags unchanged");
    doRead(8, 32'h0000DEAD, 1'b0, "R11 sdram unchanged");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R12 all responses seen", 32'(expQ.size()), 32'h0);
    finish();
  end

endmodule